// File: doc/BRIEF.md
# Signed Multiply and Divide Unit

This block performs two signed arithmetic operations over a pair of words that a processor keeps in an even/odd register pair. A multiply takes the high (even) word and a source operand as two signed W-bit values. It returns the 2W-bit signed product split across the pair. A divide takes the pair as a signed 2W-bit dividend and divides it by the signed source operand. It returns the quotient in the even word and the remainder in the odd word. Both operations also produce four condition flags: negative (N), zero (Z), overflow (V) and carry (C).

The surrounding datapath presents the pair words, the source operand and the operation select together with a single-cycle start strobe. The unit captures everything on the start edge and works iteratively, one shift-and-add or shift-and-subtract step per clock, on operand magnitudes. It applies the result signs in the final cycle. Completion is marked by a one-cycle done pulse. The result words and flags stay valid until the next completion. A zero divisor is not trapped. It is reported through the flags in the same cycle, and the pair is returned unchanged.

Top module: `muldiv_unit`

## Requirements
- R1: While reset is held, and after it is released, hi_out, lo_out, all four flags and done are 0.
- R2: With op_sel = 0 (multiply), the unit forms the signed product of hi_in and src_in, both taken as two's-complement W-bit values. The upper W bits of the product go to hi_out and the lower W bits go to lo_out. lo_in plays no part.
- R3: After a multiply, V and C are 0. Z is 1 exactly when the whole 2W-bit product is 0. N equals the most significant bit of the product.
- R4: With op_sel = 1 (divide) and a nonzero src_in, the dividend is {hi_in, lo_in} as a signed 2W-bit value. The unit divides it by signed src_in with truncation toward zero. hi_out gets the low W bits of the quotient and lo_out gets the remainder, which carries the sign of the dividend.
- R5: After a divide by a nonzero value, C is 0 and N is 1 when the exact quotient is negative. Z is 1 when the quotient is 0. V is 1 when the exact quotient lies outside -2^(W-1) to 2^(W-1)-1.
- R6: A divide with src_in = 0 sets C and V to 1, leaves N and Z at their previous values and returns hi_in and lo_in unchanged on hi_out and lo_out. done is asserted by the same edge that samples start.
- R7: done is a one-cycle pulse. It is asserted by the W-th rising edge after the start-sampling edge for a multiply, and by the 2W-th such edge for a nonzero divide.
- R8: All operands and op_sel are captured on the start-sampling edge. Later changes to the inputs, and start pulses while an operation is in progress, have no effect on that operation.
- R9: hi_out, lo_out and the flags keep their values in every cycle in which done is not asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the unit is idle |
| op_sel | input | 1 | 0 = multiply, 1 = divide |
| hi_in | input | W | Even register word (multiplicand / dividend high half) |
| lo_in | input | W | Odd register word (dividend low half) |
| src_in | input | W | Source operand (multiplier / divisor) |
| hi_out | output | W | Even result word (product high half / quotient) |
| lo_out | output | W | Odd result word (product low half / remainder) |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag (divide by zero) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default W = 16. At that width a 64-bit integer reference computes exact products, quotients and remainders, including quotients that do not fit in 16 bits. The bench can therefore reach the extreme operand pairs: the most negative product operands, a most negative dividend over -1, quotients of exactly ±32768 on either side of the overflow edge, and zero operands. At this width the 16- and 32-cycle latencies are short enough to time every operation exactly and to inject a stray start partway through a run.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2
    } state_e;

    localparam logic OP_MUL = 1'b0;
    localparam logic OP_DIV = 1'b1;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/muldiv_mul_step.sv
// One shift-and-add iteration on unsigned magnitudes.
// The partial product occupies {acc_hi, acc_lo}; the multiplier bits are
// consumed from the LSB of acc_lo and shifted out as product bits shift in.
module muldiv_mul_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] acc_lo,
    input  logic [W-1:0] mcand,
    output logic [W-1:0] nxt_hi,
    output logic [W-1:0] nxt_lo
);
    logic [W:0] sum;

    always_comb begin
        sum    = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, mcand} : {(W+1){1'b0}});
        nxt_hi = sum[W:1];
        nxt_lo = {sum[0], acc_lo[W-1:1]};
    end
endmodule

// File: rtl/muldiv_div_step.sv
// One restoring-division iteration on unsigned magnitudes.
// The dividend shifts out of the quotient register MSB-first while the
// quotient bits shift in from the right.
module muldiv_div_step #(
    parameter int W = 16,
    localparam int DW = 2 * W
) (
    input  logic [W-1:0]  rem,
    input  logic [DW-1:0] quo,
    input  logic [W-1:0]  dvsr,
    output logic [W-1:0]  rem_nxt,
    output logic [DW-1:0] quo_nxt
);
    logic [W:0] shifted;
    logic [W:0] trial;
    logic       fits;

    always_comb begin
        shifted = {rem, quo[DW-1]};
        fits    = shifted >= {1'b0, dvsr};
        trial   = shifted - {1'b0, dvsr};
        rem_nxt = fits ? trial[W-1:0] : shifted[W-1:0];
        quo_nxt = {quo[DW-2:0], fits};
    end
endmodule

// File: rtl/muldiv_fix.sv
// Final sign correction and flag derivation for both operations.
module muldiv_fix #(
    parameter int W = 16,
    localparam int DW = 2 * W,
    localparam int QX = DW + 1
) (
    input  logic          op_div,
    input  logic          neg_res,
    input  logic          neg_rem,
    input  logic [DW-1:0] mag,
    input  logic [W-1:0]  rem_mag,
    output logic [W-1:0]  res_hi,
    output logic [W-1:0]  res_lo,
    output logic          fl_n,
    output logic          fl_z,
    output logic          fl_v
);
    logic [DW-1:0] prod;
    logic [QX-1:0] qext;
    logic [QX-1:0] quo;
    logic [W-1:0]  rem_s;
    logic [W+1:0]  q_top;

    always_comb begin
        prod  = neg_res ? (~mag + DW'(1)) : mag;
        qext  = {1'b0, mag};
        quo   = neg_res ? (~qext + QX'(1)) : qext;
        rem_s = neg_rem ? (~rem_mag + W'(1)) : rem_mag;
        q_top = quo[DW:W-1];
        if (op_div) begin
            res_hi = quo[W-1:0];
            res_lo = rem_s;
            fl_n   = quo[DW];
            fl_z   = ~|quo;
            fl_v   = ~((&q_top) | (~|q_top));
        end else begin
            res_hi = prod[DW-1:W];
            res_lo = prod[W-1:0];
            fl_n   = prod[DW-1];
            fl_z   = ~|prod;
            fl_v   = 1'b0;
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_sel,
    input  logic [W-1:0] hi_in,
    input  logic [W-1:0] lo_in,
    input  logic [W-1:0] src_in,
    output logic [W-1:0] hi_out,
    output logic [W-1:0] lo_out,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_v,
    output logic         flag_c,
    output logic         done
);
    import muldiv_pkg::*;

    localparam int DW = 2 * W;
    localparam int CW = $clog2(DW);

    typedef struct packed {
        state_e          st;
        logic [CW-1:0]   cnt;
        logic            op;
        logic            zdiv;
        logic            neg_res;
        logic            neg_rem;
        logic [W-1:0]    mcand;
        logic [W-1:0]    p_hi;
        logic [DW-1:0]   p_lo;
        logic [W-1:0]    res_hi;
        logic [W-1:0]    res_lo;
        flags_t          flg;
        logic            done;
    } ctx_t;

    ctx_t s_d, s_q;

    function automatic logic [W-1:0] mag_w(input logic [W-1:0] x);
        return x[W-1] ? (~x + W'(1)) : x;
    endfunction

    logic [W-1:0]  mul_hi_n, mul_lo_n;
    logic [W-1:0]  div_rem_n;
    logic [DW-1:0] div_quo_n;
    logic [W-1:0]  fx_hi, fx_lo;
    logic          fx_n, fx_z, fx_v;
    logic [DW-1:0] fx_mag;
    logic [DW-1:0] dvd;

    muldiv_mul_step #(.W(W)) i_mul_step (
        .acc_hi (s_q.p_hi),
        .acc_lo (s_q.p_lo[W-1:0]),
        .mcand  (s_q.mcand),
        .nxt_hi (mul_hi_n),
        .nxt_lo (mul_lo_n)
    );

    muldiv_div_step #(.W(W)) i_div_step (
        .rem     (s_q.p_hi),
        .quo     (s_q.p_lo),
        .dvsr    (s_q.mcand),
        .rem_nxt (div_rem_n),
        .quo_nxt (div_quo_n)
    );

    assign fx_mag = (s_q.st == ST_DIV) ? div_quo_n : {mul_hi_n, mul_lo_n};

    muldiv_fix #(.W(W)) i_fix (
        .op_div  (s_q.st == ST_DIV),
        .neg_res (s_q.neg_res),
        .neg_rem (s_q.neg_rem),
        .mag     (fx_mag),
        .rem_mag (div_rem_n),
        .res_hi  (fx_hi),
        .res_lo  (fx_lo),
        .fl_n    (fx_n),
        .fl_z    (fx_z),
        .fl_v    (fx_v)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        dvd      = {hi_in, lo_in};
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.op      = op_sel;
                    s_d.cnt     = '0;
                    s_d.p_hi    = '0;
                    s_d.zdiv    = 1'b0;
                    s_d.neg_res = hi_in[W-1] ^ src_in[W-1];
                    if (op_sel == OP_MUL) begin
                        s_d.st      = ST_MUL;
                        s_d.mcand   = mag_w(hi_in);
                        s_d.p_lo    = {{W{1'b0}}, mag_w(src_in)};
                        s_d.neg_rem = 1'b0;
                    end else if (src_in == '0) begin
                        s_d.zdiv   = 1'b1;
                        s_d.done   = 1'b1;
                        s_d.res_hi = hi_in;
                        s_d.res_lo = lo_in;
                        s_d.flg.v  = 1'b1;
                        s_d.flg.c  = 1'b1;
                    end else begin
                        s_d.st      = ST_DIV;
                        s_d.mcand   = mag_w(src_in);
                        s_d.p_lo    = hi_in[W-1] ? (~dvd + DW'(1)) : dvd;
                        s_d.neg_rem = hi_in[W-1];
                    end
                end
            end
            ST_MUL: begin
                s_d.p_hi        = mul_hi_n;
                s_d.p_lo[W-1:0] = mul_lo_n;
                s_d.cnt         = s_q.cnt + CW'(1);
                if (s_q.cnt == CW'(W - 1)) begin
                    s_d.st     = ST_IDLE;
                    s_d.done   = 1'b1;
                    s_d.res_hi = fx_hi;
                    s_d.res_lo = fx_lo;
                    s_d.flg    = '{n: fx_n, z: fx_z, v: fx_v, c: 1'b0};
                end
            end
            ST_DIV: begin
                s_d.p_hi = div_rem_n;
                s_d.p_lo = div_quo_n;
                s_d.cnt  = s_q.cnt + CW'(1);
                if (s_q.cnt == CW'(DW - 1)) begin
                    s_d.st     = ST_IDLE;
                    s_d.done   = 1'b1;
                    s_d.res_hi = fx_hi;
                    s_d.res_lo = fx_lo;
                    s_d.flg    = '{n: fx_n, z: fx_z, v: fx_v, c: 1'b0};
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hi_out = s_q.res_hi;
    assign lo_out = s_q.res_lo;
    assign flag_n = s_q.flg.n;
    assign flag_z = s_q.flg.z;
    assign flag_v = s_q.flg.v;
    assign flag_c = s_q.flg.c;
    assign done   = s_q.done;

    // R3: multiply never reports overflow or carry
    a_r3_mul_vc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.op == OP_MUL) |-> (!flag_v && !flag_c));

    // R3: N tracks the product sign bit held in the even word
    a_r3_mul_n_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.op == OP_MUL) |-> (flag_n == hi_out[W-1]));

    // R3: Z reflects the full double-width product
    a_r3_mul_z_full: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.op == OP_MUL) |-> (flag_z == (hi_out == '0 && lo_out == '0)));

    // R5: nonzero divisor clears carry
    a_r5_div_c_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.op == OP_DIV && !s_q.zdiv) |-> !flag_c);

    // R4: a nonzero remainder has the sign of the dividend
    a_r4_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.op == OP_DIV && !s_q.zdiv && lo_out != '0) |-> (lo_out[W-1] == s_q.neg_rem));

    // R6: zero divisor raises C and V and returns the pair as presented
    a_r6_zero_div_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.zdiv) |-> (flag_c && flag_v));

    a_r6_zero_div_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.zdiv) |-> (hi_out == $past(hi_in) && lo_out == $past(lo_in)));

    // R8: no completion while iterations are still running
    a_r8_busy_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_IDLE) |-> !done);

    // R9: results only move together with done
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hi_out) && $stable(lo_out) && $stable(s_q.flg)));

endmodule

// File: tb/test_muldiv_unit.sv
module test_muldiv_unit;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op_sel = 1'b0;
    logic [W-1:0] hi_in = '0, lo_in = '0, src_in = '0;
    logic [W-1:0] hi_out, lo_out;
    logic         flag_n, flag_z, flag_v, flag_c, done;

    int checks = 0;
    int errors = 0;
    bit prev_n = 1'b0, prev_z = 1'b0;

    always #2.5 clk = ~clk;

    muldiv_unit #(.W(W)) i_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .hi_in(hi_in), .lo_in(lo_in), .src_in(src_in),
        .hi_out(hi_out), .lo_out(lo_out),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .done(done)
    );

    // {op, hi, lo, src}; op 0 = multiply, 1 = divide
    localparam logic [48:0] VEC [16] = '{
        {1'b0, 16'h0003, 16'h0000, 16'h0005},
        {1'b0, 16'hFFFD, 16'h1111, 16'h0005},
        {1'b0, 16'h8000, 16'h0000, 16'h8000},
        {1'b0, 16'h0000, 16'hFFFF, 16'h1234},
        {1'b0, 16'h7FFF, 16'h0000, 16'h8000},
        {1'b0, 16'hFFFF, 16'h0000, 16'hFFFF},
        {1'b1, 16'h0000, 16'h0064, 16'h0007},
        {1'b1, 16'hFFFF, 16'hFF9C, 16'h0007},
        {1'b1, 16'h0000, 16'h0064, 16'hFFF9},
        {1'b1, 16'h8000, 16'h0000, 16'hFFFF},
        {1'b1, 16'h0000, 16'h0000, 16'h0005},
        {1'b1, 16'h0001, 16'h0000, 16'h0001},
        {1'b1, 16'hFFFF, 16'h8000, 16'hFFFF},
        {1'b1, 16'hFFFF, 16'h8000, 16'h0001},
        {1'b1, 16'h1234, 16'h5678, 16'h0000},
        {1'b1, 16'h0000, 16'h0003, 16'h0002}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic op, input logic [W-1:0] h, input logic [W-1:0] l,
                          input logic [W-1:0] s, input bit poke);
        longint a, b, p, dd, q, r;
        logic [W-1:0] eh, el;
        bit en, ez, ev, ec;
        int elat, k;
        string rq, rf;
        if (op == 1'b0) begin
            a = longint'($signed(h)); b = longint'($signed(s)); p = a * b;
            eh = p[31:16]; el = p[15:0]; en = p[31]; ez = (p == 0); ev = 0; ec = 0;
            elat = W; rq = "R2"; rf = "R3";
        end else if (s == '0) begin
            eh = h; el = l; en = prev_n; ez = prev_z; ev = 1; ec = 1;
            elat = 0; rq = "R6"; rf = "R6";
        end else begin
            dd = longint'($signed({h, l})); b = longint'($signed(s));
            q = dd / b; r = dd % b;
            eh = q[15:0]; el = r[15:0]; en = (q < 0); ez = (q == 0);
            ev = (q > 32767) || (q < -32768); ec = 0;
            elat = 2 * W; rq = "R4"; rf = "R5";
        end
        @(negedge clk);
        start = 1'b1; op_sel = op; hi_in = h; lo_in = l; src_in = s;
        @(negedge clk);
        // R8: scramble operands after capture
        start = 1'b0; op_sel = ~op; hi_in = ~h; lo_in = ~l; src_in = ~s;
        k = 0;
        while (!done && k < 200) begin
            @(negedge clk);
            k++;
            if (poke && k == 5) begin start = 1'b1; op_sel = 1'b1; src_in = '0; end
            else start = 1'b0;
        end
        chk(hi_out == eh, rq, "even word", 64'(hi_out), 64'(eh));
        chk(lo_out == el, rq, "odd word", 64'(lo_out), 64'(el));
        chk({flag_n, flag_z, flag_v, flag_c} == {en, ez, ev, ec}, rf, "flags NZVC",
            64'({flag_n, flag_z, flag_v, flag_c}), 64'({en, ez, ev, ec}));
        chk(k == elat, poke ? "R8" : "R7", "latency", 64'(k), 64'(elat));
        prev_n = en; prev_z = ez;
        @(negedge clk);
        chk(!done, "R7", "done pulse width", 64'(done), 64'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] sh, sl;
        logic [3:0]   sf;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({hi_out, lo_out, flag_n, flag_z, flag_v, flag_c, done} == '0, "R1", "in reset",
            64'({hi_out, lo_out, flag_n, flag_z, flag_v, flag_c, done}), 64'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({hi_out, lo_out, flag_n, flag_z, flag_v, flag_c, done} == '0, "R1", "after reset",
            64'({hi_out, lo_out, flag_n, flag_z, flag_v, flag_c, done}), 64'(0));

        for (int i = 0; i < 16; i++)
            run_op(VEC[i][48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], 1'b0);

        // R6: zero divisor keeps Z=1 from a zero product
        run_op(1'b0, 16'h0000, 16'h0000, 16'h4321, 1'b0);
        run_op(1'b1, 16'hABCD, 16'h0001, 16'h0000, 1'b0);
        // R6: keeps N=1 from a negative product
        run_op(1'b0, 16'hFFFE, 16'h0000, 16'h0003, 1'b0);
        run_op(1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b0);

        // R8: stray start during a multiply and during a divide
        run_op(1'b0, 16'h1234, 16'h0000, 16'hFF00, 1'b1);
        run_op(1'b1, 16'hF000, 16'h0001, 16'h0123, 1'b1);

        // R9: outputs hold with start low while inputs wander
        sh = hi_out; sl = lo_out; sf = {flag_n, flag_z, flag_v, flag_c};
        for (int j = 0; j < 6; j++) begin
            hi_in = 16'(j * 97); lo_in = 16'(j * 13); src_in = '0; op_sel = j[0];
            @(negedge clk);
        end
        chk({hi_out, lo_out, flag_n, flag_z, flag_v, flag_c} == {sh, sl, sf}, "R9", "hold",
            64'({hi_out, lo_out, flag_n, flag_z, flag_v, flag_c}), 64'({sh, sl, sf}));
        chk(!done, "R9", "no done while idle", 64'(done), 64'(0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule